// File: doc/BRIEF.md
# Calendar Clock Update Engine

This block keeps the time of day and the calendar in a small byte-addressed register file and advances it once per second. A timebase tick, nominally 32.768 kHz, is divided down to one update per second. Each update is a single commit clock. In that clock seconds, minutes, hours, day of week, day of month, month and a two-digit year are advanced with carries, the new time is compared against an alarm, and the results are written back.

Software uses one host port to set the clock, read it and configure it. Fields are held either as packed BCD or as plain binary, and hours use either a 24-hour form or a 12-hour form with a PM flag. An update-in-progress flag rises a fixed number of ticks before each commit, so that software can tell when a read could be torn. A set-inhibit bit stops updates while software loads a new time. If a host write lands in the commit clock, the host write wins.

Top module: `cal_clock_engine`

## Requirements
- R1: After reset the time/date bytes read 00h, with day of week, day of month and month at 01h. Control A reads 26h, control B reads 02h, the flag byte (Ch) reads 00h and the status byte (Dh) reads 80h.
- R2: While updates are enabled, one commit happens for every TICKS_PER_SEC ticks, so commits are exactly that many ticks apart.
- R3: Update-in-progress (control A bit 7) rises LEAD_TICKS ticks before the commit, stays high through the commit clock and falls right after it.
- R4: While the set-inhibit bit (control B bit 7) is 1, no commit occurs, update-in-progress stays 0 and the divider restarts from zero.
- R5: Commits and update-in-progress occur only while the divider select (control A bits 6:4) equals 010b.
- R6: With control B bit 2 = 0, fields are packed BCD with the tens digit in bits 7:4. Each digit rolls past 9, and 23:59:59 on 31 Dec of year 99 advances to 00:00:00 on 01 Jan of year 00, with day of week going from 7 to 1.
- R7: With control B bit 2 = 1, the same fields hold plain binary values with the same limits.
- R8: With control B bit 1 = 0, hours run 12,1..11 AM, then 12,1..11 PM. Bit 7 of the hours byte is PM, 11 PM advances to 12 AM, and the day advances only on that step.
- R9: The day of month wraps after 31, 30 or 28 days according to the month, and after 29 days in February when the year is a multiple of 4.
- R10: During the commit clock, a host read of any time/date byte (00h–09h) returns FFh.
- R11: A host write to a time/date byte in the commit clock stores the host value in place of the advanced value.
- R12: After a commit, flag byte bit 5 is set if the new seconds, minutes and hours each equal their alarm byte (01h, 03h, 05h). An alarm byte with bits 7:6 = 11b matches any value.
- R13: Each commit sets flag byte bit 4. A host read of the flag byte with the read strobe clears bits 5 and 4, unless a commit happens in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick enable, one clock per tick |
| bus_addr_i | input | 4 | Register byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe; only the flag byte reacts to it |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from bus_addr_i |

## Verification
The bench builds the engine with TICKS_PER_SEC = 64 and LEAD_TICKS = 8 and holds the tick high on every clock, so one second takes 64 clocks. Because seconds are that short, many updates fit in a run, and the year, month, leap-day and 12-hour boundaries are each reached by loading a time one second before them. With these settings the update-in-progress window and the spacing between commits can be counted to the exact clock, and the single commit clock can be found from the host port so that a read and a colliding write can be aimed at it.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  localparam logic [3:0] ADR_SEC    = 4'h0;
  localparam logic [3:0] ADR_SEC_AL = 4'h1;
  localparam logic [3:0] ADR_MIN    = 4'h2;
  localparam logic [3:0] ADR_MIN_AL = 4'h3;
  localparam logic [3:0] ADR_HR     = 4'h4;
  localparam logic [3:0] ADR_HR_AL  = 4'h5;
  localparam logic [3:0] ADR_DOW    = 4'h6;
  localparam logic [3:0] ADR_DOM    = 4'h7;
  localparam logic [3:0] ADR_MON    = 4'h8;
  localparam logic [3:0] ADR_YR     = 4'h9;
  localparam logic [3:0] ADR_CTLA   = 4'hA;
  localparam logic [3:0] ADR_CTLB   = 4'hB;
  localparam logic [3:0] ADR_FLG    = 4'hC;
  localparam logic [3:0] ADR_STS    = 4'hD;
  localparam int unsigned N_TM      = 10;
  localparam logic [2:0] DIV_OK     = 3'b010;

  function automatic logic [6:0] fld_dec(input logic [7:0] v, input logic bin);
    if (bin) return v[6:0];
    return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction

  function automatic logic [7:0] fld_enc(input logic [6:0] b, input logic bin);
    logic [6:0] t, o;
    if (bin) return {1'b0, b};
    t = b / 7'd10;
    o = b % 7'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] m, input logic [6:0] y);
    case (m)
      7'd2: return (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      default: return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_step.sv
`timescale 1ns/1ps
module cal_step
  import cal_pkg::*;
#(
  parameter int unsigned LO = 0
) (
  input  logic [7:0] val_i,
  input  logic       bin_i,
  input  logic       inc_i,
  input  logic [6:0] hi_i,
  output logic [7:0] nxt_o,
  output logic       wrap_o
);
  logic [6:0] cur, nb;

  always_comb begin
    cur    = fld_dec(val_i, bin_i);
    wrap_o = inc_i && (cur >= hi_i);
    nb     = wrap_o ? 7'(LO) : cur + 7'd1;
    nxt_o  = inc_i ? fld_enc(nb, bin_i) : val_i;
  end
endmodule

// File: rtl/cal_hour_step.sv
`timescale 1ns/1ps
module cal_hour_step
  import cal_pkg::*;
(
  input  logic [7:0] val_i,
  input  logic       bin_i,
  input  logic       h24_i,
  input  logic       inc_i,
  output logic [7:0] nxt_o,
  output logic       wrap_o
);
  logic [6:0] cur, nb;
  logic       pm, pm_n;
  logic [7:0] enc;

  always_comb begin
    pm     = val_i[7];
    pm_n   = pm;
    wrap_o = 1'b0;
    if (h24_i) begin
      cur = fld_dec(val_i, bin_i);
      if (cur >= 7'd23) begin
        nb     = 7'd0;
        wrap_o = inc_i;
      end else begin
        nb = cur + 7'd1;
      end
      enc   = fld_enc(nb, bin_i);
    end else begin
      cur = fld_dec({1'b0, val_i[6:0]}, bin_i);
      if (cur >= 7'd12) begin
        nb = 7'd1;
      end else if (cur == 7'd11) begin
        nb     = 7'd12;
        pm_n   = !pm;
        wrap_o = inc_i && pm;   // 11 PM -> 12 AM rolls the day
      end else begin
        nb = cur + 7'd1;
      end
      enc   = fld_enc(nb, bin_i);
      enc[7] = pm_n;
    end
    nxt_o = inc_i ? enc : val_i;
  end
endmodule

// File: rtl/cal_divider.sv
`timescale 1ns/1ps
module cal_divider #(
  parameter int unsigned TICKS = 32768,
  parameter int unsigned LEAD  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  output logic uip_o,
  output logic upd_o
);
  localparam int unsigned CW = $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
  localparam logic [CW-1:0] WARN = CW'(TICKS - LEAD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      uip_o <= 1'b0;
      upd_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      uip_o <= 1'b0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= tick_i && (cnt_q == LAST);
      if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (upd_o) uip_o <= 1'b0;
      else if (tick_i && cnt_q == WARN) uip_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cal_clock_engine.sv
`timescale 1ns/1ps
module cal_clock_engine
  import cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned LEAD_TICKS    = 16,
  parameter logic [7:0]  BLOCK_VAL     = 8'hFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [3:0] bus_addr_i,
  input  logic       bus_wr_i,
  input  logic       bus_rd_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o
);
  localparam logic [7:0] TM_RST [N_TM] =
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

  logic [7:0] tm_q  [N_TM];
  logic [7:0] tm_nxt[N_TM];
  logic [6:0] ctla_q;
  logic [7:0] ctlb_q;
  logic       af_q, uf_q;
  logic       run, upd, uip, bin, h24;

  assign bin = ctlb_q[2];
  assign h24 = ctlb_q[1];
  assign run = (ctla_q[6:4] == DIV_OK) && !ctlb_q[7];

  cal_divider #(.TICKS(TICKS_PER_SEC), .LEAD(LEAD_TICKS)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .run_i(run),
    .uip_o(uip), .upd_o(upd)
  );

  // carry chain
  logic [7:0] sec_n, min_n, hr_n, dow_n, dom_n, mon_n, yr_n;
  logic       sec_w, min_w, hr_w, dow_w, dom_w, mon_w, yr_w;
  logic [6:0] dim;

  assign dim = month_len(fld_dec(tm_q[ADR_MON], bin), fld_dec(tm_q[ADR_YR], bin));

  cal_step #(.LO(0)) u_sec (.val_i(tm_q[ADR_SEC]), .bin_i(bin), .inc_i(upd),
    .hi_i(7'd59), .nxt_o(sec_n), .wrap_o(sec_w));
  cal_step #(.LO(0)) u_min (.val_i(tm_q[ADR_MIN]), .bin_i(bin), .inc_i(sec_w),
    .hi_i(7'd59), .nxt_o(min_n), .wrap_o(min_w));
  cal_hour_step u_hr (.val_i(tm_q[ADR_HR]), .bin_i(bin), .h24_i(h24), .inc_i(min_w),
    .nxt_o(hr_n), .wrap_o(hr_w));
  cal_step #(.LO(1)) u_dow (.val_i(tm_q[ADR_DOW]), .bin_i(bin), .inc_i(hr_w),
    .hi_i(7'd7), .nxt_o(dow_n), .wrap_o(dow_w));
  cal_step #(.LO(1)) u_dom (.val_i(tm_q[ADR_DOM]), .bin_i(bin), .inc_i(hr_w),
    .hi_i(dim), .nxt_o(dom_n), .wrap_o(dom_w));
  cal_step #(.LO(1)) u_mon (.val_i(tm_q[ADR_MON]), .bin_i(bin), .inc_i(dom_w),
    .hi_i(7'd12), .nxt_o(mon_n), .wrap_o(mon_w));
  cal_step #(.LO(0)) u_yr (.val_i(tm_q[ADR_YR]), .bin_i(bin), .inc_i(mon_w),
    .hi_i(7'd99), .nxt_o(yr_n), .wrap_o(yr_w));

  logic unused_w;
  assign unused_w = dow_w ^ yr_w;

  always_comb begin
    for (int i = 0; i < N_TM; i++) tm_nxt[i] = tm_q[i];
    tm_nxt[ADR_SEC] = sec_n;
    tm_nxt[ADR_MIN] = min_n;
    tm_nxt[ADR_HR]  = hr_n;
    tm_nxt[ADR_DOW] = dow_n;
    tm_nxt[ADR_DOM] = dom_n;
    tm_nxt[ADR_MON] = mon_n;
    tm_nxt[ADR_YR]  = yr_n;
  end

  function automatic logic al_match(input logic [7:0] v, input logic [7:0] a);
    return (a[7:6] == 2'b11) || (v == a);
  endfunction

  logic al_hit;
  assign al_hit = al_match(sec_n, tm_q[ADR_SEC_AL]) &&
                  al_match(min_n, tm_q[ADR_MIN_AL]) &&
                  al_match(hr_n,  tm_q[ADR_HR_AL]);

  logic host_wr;
  assign host_wr = bus_wr_i;

  // host write beats the commit on the same byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_TM; i++) tm_q[i] <= TM_RST[i];
    end else begin
      for (int i = 0; i < N_TM; i++) begin
        if (host_wr && bus_addr_i == 4'(i)) tm_q[i] <= bus_wdata_i;
        else if (upd)                       tm_q[i] <= tm_nxt[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctla_q <= 7'h26;
      ctlb_q <= 8'h02;
    end else if (host_wr) begin
      if (bus_addr_i == ADR_CTLA) ctla_q <= bus_wdata_i[6:0];
      if (bus_addr_i == ADR_CTLB) ctlb_q <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      af_q <= 1'b0;
      uf_q <= 1'b0;
    end else if (upd) begin
      uf_q <= 1'b1;
      af_q <= af_q | al_hit;
    end else if (bus_rd_i && bus_addr_i == ADR_FLG) begin
      uf_q <= 1'b0;
      af_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = 8'h00;
    if (bus_addr_i <= ADR_YR) begin
      bus_rdata_o = upd ? BLOCK_VAL : tm_q[bus_addr_i];
    end else begin
      case (bus_addr_i)
        ADR_CTLA: bus_rdata_o = {uip, ctla_q};
        ADR_CTLB: bus_rdata_o = ctlb_q;
        ADR_FLG:  bus_rdata_o = {2'b00, af_q, uf_q, 4'h0};
        ADR_STS:  bus_rdata_o = 8'h80;
        default:  bus_rdata_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/cal_clock_engine_chk.sv
`timescale 1ns/1ps
module cal_clock_engine_chk #(
  parameter int unsigned LEAD = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       upd_i,
  input logic       uip_i,
  input logic       set_i,
  input logic       bus_wr_i,
  input logic [3:0] bus_addr_i,
  input logic [7:0] bus_wdata_i,
  input logic [7:0] sec_i,
  input logic       uf_i
);
  localparam int unsigned LW = $clog2(LEAD + 1) + 1;
  logic [LW-1:0] lead_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           lead_q <= '0;
    else if (!uip_i)                       lead_q <= '0;
    else if (tick_i && lead_q < LW'(LEAD)) lead_q <= lead_q + 1'b1;
  end

  a_r2_commit_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> $past(tick_i));
  a_r3_uip_before_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> uip_i);
  a_r3_uip_lead_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> (lead_q >= LW'(LEAD)));
  a_r3_uip_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !uip_i);
  a_r4_set_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(set_i) |-> !upd_i);
  a_r11_host_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && bus_wr_i && bus_addr_i == 4'h0) |=> sec_i == $past(bus_wdata_i));
  a_r13_uf_after_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> uf_i);
endmodule

bind cal_clock_engine cal_clock_engine_chk #(.LEAD(LEAD_TICKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .upd_i(upd), .uip_i(uip),
  .set_i(ctlb_q[7]), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .sec_i(tm_q[0]), .uf_i(uf_q)
);

// File: tb/cal_clock_engine_tb.sv
`timescale 1ns/1ps
module cal_clock_engine_tb;
  localparam int T = 64;
  localparam int L = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] addr = 4'h0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cal_clock_engine #(.TICKS_PER_SEC(T), .LEAD_TICKS(L)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_b(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_b(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic rd_flg(output logic [7:0] d);
    @(negedge clk); addr = 4'hC; rd = 1'b1; #1; d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic load(input logic [7:0] b, input logic [7:0] hr, input logic [7:0] mn,
                      input logic [7:0] sc, input logic [7:0] dw, input logic [7:0] dm,
                      input logic [7:0] mo, input logic [7:0] yr);
    wr_b(4'hB, b | 8'h80);
    wr_b(4'h0, sc); wr_b(4'h2, mn); wr_b(4'h4, hr);
    wr_b(4'h6, dw); wr_b(4'h7, dm); wr_b(4'h8, mo); wr_b(4'h9, yr);
    wr_b(4'hB, b);
  endtask

  // waits for a full update-in-progress pulse; hi = clocks high, n = clocks stepped
  task automatic wait_upd(output int hi, output int n, output bit ok);
    bit seen = 0;
    hi = 0; n = 0; ok = 0;
    @(negedge clk); n++; addr = 4'hA;
    for (int i = 0; i < 4 * T; i++) begin
      #1;
      if (rdata[7]) begin seen = 1; hi++; end
      else if (seen) begin ok = 1; break; end
      @(negedge clk); n++;
    end
  endtask

  task automatic upd_once(input string req);
    int hi, n; bit ok;
    wait_upd(hi, n, ok);
    check({req, " update seen"}, int'(ok), 1);
  endtask

  task automatic expect_b(input string req, input logic [3:0] a, input logic [7:0] e);
    logic [7:0] d;
    rd_b(a, d);
    check(req, d, e);
  endtask

  task automatic t_reset();
    expect_b("R1 sec", 4'h0, 8'h00);
    expect_b("R1 hr", 4'h4, 8'h00);
    expect_b("R1 dow", 4'h6, 8'h01);
    expect_b("R1 dom", 4'h7, 8'h01);
    expect_b("R1 mon", 4'h8, 8'h01);
    expect_b("R1 yr", 4'h9, 8'h00);
    expect_b("R1 ctla", 4'hA, 8'h26);
    expect_b("R1 ctlb", 4'hB, 8'h02);
    expect_b("R1 flg", 4'hC, 8'h00);
    expect_b("R1 sts", 4'hD, 8'h80);
  endtask

  task automatic t_timing();
    int hi, n; bit ok;
    wait_upd(hi, n, ok);
    check("R3 uip high clocks", hi, L + 1);
    wait_upd(hi, n, ok);
    check("R2 commit spacing", n, T);
    check("R3 uip high clocks again", hi, L + 1);
  endtask

  task automatic t_bcd();
    load(8'h02, 8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h12, 8'h99);
    upd_once("R6");
    expect_b("R6 sec wrap", 4'h0, 8'h00);
    expect_b("R6 min wrap", 4'h2, 8'h00);
    expect_b("R6 hr wrap", 4'h4, 8'h00);
    expect_b("R6 dow 7->1", 4'h6, 8'h01);
    expect_b("R6 dom", 4'h7, 8'h01);
    expect_b("R6 mon", 4'h8, 8'h01);
    expect_b("R6 yr 99->00", 4'h9, 8'h00);
    load(8'h02, 8'h09, 8'h29, 8'h09, 8'h03, 8'h15, 8'h06, 8'h21);
    upd_once("R6");
    expect_b("R6 digit 09->10", 4'h0, 8'h10);
    expect_b("R6 min kept", 4'h2, 8'h29);
  endtask

  task automatic t_calendar();
    load(8'h06, 8'd23, 8'd59, 8'd59, 8'd3, 8'd28, 8'd2, 8'd4);
    upd_once("R9");
    expect_b("R7 R9 leap feb 28->29", 4'h7, 8'd29);
    expect_b("R7 mon stays feb", 4'h8, 8'd2);
    expect_b("R7 dow bin", 4'h6, 8'd4);
    expect_b("R7 hr bin wrap", 4'h4, 8'd0);
    load(8'h06, 8'd23, 8'd59, 8'd59, 8'd3, 8'd29, 8'd2, 8'd4);
    upd_once("R9");
    expect_b("R9 leap feb 29->1", 4'h7, 8'd1);
    expect_b("R9 -> march", 4'h8, 8'd3);
    load(8'h06, 8'd23, 8'd59, 8'd59, 8'd3, 8'd28, 8'd2, 8'd5);
    upd_once("R9");
    expect_b("R9 plain feb 28->1", 4'h7, 8'd1);
    load(8'h06, 8'd10, 8'd59, 8'd59, 8'd3, 8'd28, 8'd2, 8'd5);
    upd_once("R7");
    expect_b("R7 bin min 59->0", 4'h2, 8'd0);
    expect_b("R7 bin hr 10->11", 4'h4, 8'd11);
    load(8'h02, 8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h04, 8'h21);
    upd_once("R9");
    expect_b("R9 apr 30->1", 4'h7, 8'h01);
    expect_b("R9 -> may", 4'h8, 8'h05);
    load(8'h02, 8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h01, 8'h21);
    upd_once("R9");
    expect_b("R9 jan 30->31", 4'h7, 8'h31);
  endtask

  task automatic t_12h();
    load(8'h00, 8'h11, 8'h59, 8'h59, 8'h02, 8'h05, 8'h03, 8'h21);
    upd_once("R8");
    expect_b("R8 11AM->12PM", 4'h4, 8'h92);
    expect_b("R8 no day step at noon", 4'h7, 8'h05);
    load(8'h00, 8'h91, 8'h59, 8'h59, 8'h02, 8'h05, 8'h03, 8'h21);
    upd_once("R8");
    expect_b("R8 11PM->12AM", 4'h4, 8'h12);
    expect_b("R8 day steps at midnight", 4'h7, 8'h06);
    load(8'h00, 8'h12, 8'h59, 8'h59, 8'h02, 8'h05, 8'h03, 8'h21);
    upd_once("R8");
    expect_b("R8 12AM->1AM", 4'h4, 8'h01);
    load(8'h00, 8'h92, 8'h59, 8'h59, 8'h02, 8'h05, 8'h03, 8'h21);
    upd_once("R8");
    expect_b("R8 12PM->1PM", 4'h4, 8'h81);
  endtask

  task automatic t_inhibit();
    int seen = 0;
    load(8'h02, 8'h08, 8'h00, 8'h30, 8'h02, 8'h05, 8'h03, 8'h21);
    wr_b(4'hB, 8'h82);
    for (int i = 0; i < 3 * T; i++) begin
      @(negedge clk); addr = 4'hA; #1;
      if (rdata[7]) seen++;
    end
    check("R4 no uip while set", seen, 0);
    expect_b("R4 sec frozen", 4'h0, 8'h30);
    wr_b(4'hB, 8'h02);
    wr_b(4'hA, 8'h76);
    seen = 0;
    for (int i = 0; i < 3 * T; i++) begin
      @(negedge clk); addr = 4'hA; #1;
      if (rdata[7]) seen++;
    end
    check("R5 no uip bad divider", seen, 0);
    expect_b("R5 sec frozen", 4'h0, 8'h30);
    wr_b(4'hA, 8'h26);
    upd_once("R5");
    expect_b("R5 resumes", 4'h0, 8'h31);
  endtask

  task automatic t_collide();
    bit hit = 0;
    load(8'h02, 8'h08, 8'h20, 8'h15, 8'h02, 8'h05, 8'h03, 8'h21);
    for (int i = 0; i < 3 * T; i++) begin
      @(negedge clk); addr = 4'h0; #1;
      if (rdata == 8'hFF) begin
        hit = 1;
        wdata = 8'h40; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        break;
      end
    end
    check("R10 block read FF", int'(hit), 1);
    expect_b("R11 host value kept", 4'h0, 8'h40);
    expect_b("R11 other fields unchanged", 4'h2, 8'h20);
  endtask

  task automatic t_alarm();
    logic [7:0] d;
    load(8'h02, 8'h10, 8'h30, 8'h05, 8'h02, 8'h05, 8'h03, 8'h21);
    wr_b(4'hB, 8'h82);
    wr_b(4'h1, 8'h06); wr_b(4'h3, 8'h30); wr_b(4'h5, 8'h10);
    rd_flg(d);
    wr_b(4'hB, 8'h02);
    upd_once("R12");
    rd_flg(d);
    check("R12 R13 alarm+update flags", d, 8'h30);
    rd_flg(d);
    check("R13 flags cleared by read", d, 8'h00);
    wr_b(4'h5, 8'hC0); wr_b(4'h1, 8'h07);
    upd_once("R12");
    rd_flg(d);
    check("R12 dont-care hour match", d, 8'h30);
    wr_b(4'h1, 8'h20);
    upd_once("R12");
    rd_flg(d);
    check("R12 R13 mismatch only update", d, 8'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    tick = 1'b1;
    t_timing();
    t_bcd();
    t_calendar();
    t_12h();
    t_inhibit();
    t_collide();
    t_alarm();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule